// File: doc/BRIEF.md
# Dual-Port Banked Load Cache Array

This block is the storage and lookup core of a first-level data cache that serves two independent 8-byte loads in the same clock cycle. Every 64-byte line is cut into eight 8-byte words. Word k of every line lives in data bank k, and each bank is a single-ported RAM. Each load port has its own private copy of the tag and valid array. The two lookups therefore never compete for tag bandwidth. They compete only when both need the same data bank.

A load is offered with a ready/valid handshake. The result appears on that port's response outputs one cycle after acceptance. A hit returns the addressed 8-byte word. A miss returns no data and reports the line address, so that an outer controller can fetch the line. Refills arrive on a line-fill port. A refill writes all eight banks and both tag copies in one cycle. The way it overwrites is an invalid way if one exists, and otherwise a per-set rotation.

Top module: `dcb_dual_load_cache`

## Requirements
- R1: After reset every line is invalid, so any accepted load misses, no response is valid, and both ports show ready.
- R2: Address decoding: bits [5:3] pick the word within the line and the bank, the next log2(SETS) bits pick the set, and the remaining upper bits form the tag. A hit returns word k of the line, which is bits [64k+63:64k] of the fill data that loaded it.
- R3: When both ports present loads to different banks, both are accepted in the same cycle. When both present loads to the same bank, port 0 is accepted and port 1 sees ready low for that cycle.
- R4: One fill makes the line visible to both ports. After the fill, a load of that line hits on port 0 and on port 1.
- R5: A port's response valid is high in exactly the cycle after a handshake on that port, and low otherwise.
- R6: On a miss the response shows miss high, hit low and data zero, and it reports the line address (address bits [ADDR_W-1:6]).
- R7: A fill goes to the lowest-numbered invalid way of its set. When every way of the set is valid, the fill goes to the way given by a per-set counter. The counter starts at way 0 and advances by one, wrapping, after each such fill. Other sets are unaffected.
- R8: While fill_valid is high, both request ports show ready low. The fill completes in that single cycle.
- R9: Address bits [2:0] have no effect on which word is returned or on whether the load hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 2 | Load request valid, one bit per port |
| req_ready | output | 2 | Load request ready, one bit per port |
| req_addr | input | 2 x ADDR_W | Load byte address per port |
| rsp_valid | output | 2 | Response valid per port |
| rsp_hit | output | 2 | Response is a hit |
| rsp_miss | output | 2 | Response is a miss |
| rsp_data | output | 2 x 64 | Returned 8-byte word (zero on miss) |
| rsp_line | output | 2 x (ADDR_W-6) | Line address of the response |
| fill_valid | input | 1 | Line fill strobe |
| fill_line | input | ADDR_W-6 | Line address being filled |
| fill_data | input | 512 | Line contents, word k in bits [64k+63:64k] |

## Verification
The bench builds the array with its defaults: 32-bit addresses, 16 sets and 2 ways. With two ways, a third fill into one set already forces the rotation counter to pick a victim. A fourth fill shows the counter wrapping, so R7 can be reached with a handful of directed fills. Sixteen sets let random lines spread across sets while still landing often on the same set as a pooled line. Eight banks against two random ports produce same-bank collisions about one time in eight, so the random phase exercises the port-1 stall frequently alongside the directed conflict case.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
   localparam int WORD_BITS  = 64;
   localparam int NUM_BANKS  = 8;
   localparam int LINE_OFF_W = 6;
   localparam int LINE_BITS  = WORD_BITS * NUM_BANKS;
   localparam int BANK_W     = $clog2(NUM_BANKS);

   function automatic int way_width(input int ways);
      return (ways > 1) ? $clog2(ways) : 1;
   endfunction
endpackage

// File: rtl/dcb_tag_copy.sv
module dcb_tag_copy #(
   parameter int SETS  = 16,
   parameter int WAYS  = 2,
   parameter int TAG_W = 22,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = dcb_pkg::way_width(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_en,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [WAY_W-1:0] lk_way,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [WAY_W-1:0] fill_way,
   output logic [WAYS-1:0]  set_valid
);
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAYS-1:0]  match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
   end

   always_comb begin
      lk_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (match[w]) lk_way = WAY_W'(w);
   end
   assign lk_hit    = |match;
   assign set_valid = vld_q[fill_set];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (fill_en) begin
         vld_q[fill_set][fill_way] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
   end

   // R4: a line is never resident in two ways of one copy
   a_r4_single_way_match: assert property (@(posedge clk) disable iff (!rst_n)
      lk_en |-> $onehot0(match));
endmodule

// File: rtl/dcb_data_bank.sv
module dcb_data_bank #(
   parameter int ENTRIES = 32,
   parameter int WIDTH   = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WIDTH-1:0] rd_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDTH-1:0] wr_data
);
   logic [WIDTH-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
      if (rd_en) rd_data <= mem[rd_idx];
   end

   // R8: single-ported RAM, a fill never shares a cycle with a read
   a_r8_bank_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));
endmodule

// File: rtl/dcb_victim.sv
module dcb_victim #(
   parameter int SETS = 16,
   parameter int WAYS = 2,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = dcb_pkg::way_width(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [SET_W-1:0] fill_set,
   input  logic [WAYS-1:0]  set_valid,
   output logic [WAY_W-1:0] victim
);
   logic [WAY_W-1:0] rr_q [SETS];

   always_comb begin
      victim = rr_q[fill_set];
      for (int w = WAYS - 1; w >= 0; w--)
         if (!set_valid[w]) victim = WAY_W'(w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      end else if (fill_en && (&set_valid)) begin
         rr_q[fill_set] <= (rr_q[fill_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[fill_set] + 1'b1;
      end
   end

   // R7: with a free way available the victim must be a free way
   a_r7_free_way_first: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !(&set_valid)) |-> !set_valid[victim]);
endmodule

// File: rtl/dcb_dual_load_cache.sv
module dcb_dual_load_cache #(
   parameter int ADDR_W = 32,
   parameter int SETS   = 16,
   parameter int WAYS   = 2,
   localparam int LINE_W  = ADDR_W - dcb_pkg::LINE_OFF_W,
   localparam int SET_W   = $clog2(SETS),
   localparam int TAG_W   = LINE_W - SET_W,
   localparam int WAY_W   = dcb_pkg::way_width(WAYS),
   localparam int ENTRIES = SETS * WAYS,
   localparam int IDX_W   = SET_W + WAY_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             req_valid,
   output logic [1:0]             req_ready,
   input  logic [1:0][ADDR_W-1:0] req_addr,
   output logic [1:0]             rsp_valid,
   output logic [1:0]             rsp_hit,
   output logic [1:0]             rsp_miss,
   output logic [1:0][63:0]       rsp_data,
   output logic [1:0][LINE_W-1:0] rsp_line,
   input  logic                   fill_valid,
   input  logic [LINE_W-1:0]      fill_line,
   input  logic [511:0]           fill_data
);
   import dcb_pkg::*;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the set count");
   end

   logic [SET_W-1:0]  set_w  [2];
   logic [TAG_W-1:0]  tag_w  [2];
   logic [BANK_W-1:0] bank_w [2];
   logic [1:0]        hit_w;
   logic [WAY_W-1:0]  way_w  [2];
   logic [WAYS-1:0]   svalid [2];
   logic [1:0]        acc;
   logic              same_bank;
   logic [WAY_W-1:0]  victim;
   logic [SET_W-1:0]  fill_set;
   logic [TAG_W-1:0]  fill_tag;
   logic [NUM_BANKS-1:0] sel0, sel1;
   logic [WORD_BITS-1:0] bank_rd [NUM_BANKS];

   logic [1:0]        hit_q;
   logic [BANK_W-1:0] bank_q [2];
   logic [1:0]        vld_q;
   logic              unused_offs;

   assign unused_offs = ^{req_addr[0][2:0], req_addr[1][2:0]};
   assign fill_set    = fill_line[SET_W-1:0];
   assign fill_tag    = fill_line[LINE_W-1:SET_W];

   // port 0 has priority on a bank collision; a fill stalls both ports
   assign same_bank    = (bank_w[0] == bank_w[1]);
   assign req_ready[0] = !fill_valid;
   assign req_ready[1] = !fill_valid && !(req_valid[0] && same_bank);
   assign acc          = req_valid & req_ready;

   for (genvar p = 0; p < 2; p++) begin : g_port
      assign bank_w[p] = req_addr[p][5:3];
      assign set_w[p]  = req_addr[p][LINE_OFF_W +: SET_W];
      assign tag_w[p]  = req_addr[p][ADDR_W-1 -: TAG_W];

      dcb_tag_copy #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tag (
         .clk(clk), .rst_n(rst_n),
         .lk_en(acc[p]), .lk_set(set_w[p]), .lk_tag(tag_w[p]),
         .lk_hit(hit_w[p]), .lk_way(way_w[p]),
         .fill_en(fill_valid), .fill_set(fill_set), .fill_tag(fill_tag),
         .fill_way(victim), .set_valid(svalid[p]));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[p]  <= 1'b0;
            hit_q[p]  <= 1'b0;
            bank_q[p] <= '0;
            rsp_line[p] <= '0;
         end else begin
            vld_q[p] <= acc[p];
            if (acc[p]) begin
               hit_q[p]    <= hit_w[p];
               bank_q[p]   <= bank_w[p];
               rsp_line[p] <= req_addr[p][ADDR_W-1:LINE_OFF_W];
            end
         end
      end

      assign rsp_valid[p] = vld_q[p];
      assign rsp_hit[p]   = vld_q[p] && hit_q[p];
      assign rsp_miss[p]  = vld_q[p] && !hit_q[p];
      assign rsp_data[p]  = rsp_hit[p] ? bank_rd[bank_q[p]] : '0;

      // R5: a response follows each handshake, and only a handshake
      a_r5_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
         acc[p] |=> rsp_valid[p]);
      a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
         !acc[p] |=> !rsp_valid[p]);
   end

   dcb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_valid), .fill_set(fill_set),
      .set_valid(svalid[0]), .victim(victim));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [IDX_W-1:0] rd_idx;
      assign sel0[b] = acc[0] && hit_w[0] && (bank_w[0] == BANK_W'(b));
      assign sel1[b] = acc[1] && hit_w[1] && (bank_w[1] == BANK_W'(b));
      assign rd_idx  = sel0[b] ? {set_w[0], way_w[0]} : {set_w[1], way_w[1]};

      dcb_data_bank #(.ENTRIES(ENTRIES), .WIDTH(WORD_BITS)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .rd_en(sel0[b] | sel1[b]), .rd_idx(rd_idx), .rd_data(bank_rd[b]),
         .wr_en(fill_valid), .wr_idx({fill_set, victim}),
         .wr_data(fill_data[b*WORD_BITS +: WORD_BITS]));

      // R3: no bank is ever asked for two words in one cycle
      a_r3_bank_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
         !(sel0[b] && sel1[b]));
   end

   // R3: a collision stalls port 1 and lets port 0 through
   a_r3_port0_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid == 2'b11 && same_bank && !fill_valid) |-> (req_ready == 2'b01));
   // R8: fill blocks both ports
   a_r8_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (req_ready == 2'b00));
   // R4: the two tag copies hold the same valid bits for the set being filled
   a_r4_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (svalid[0] == svalid[1]));
endmodule

// File: tb/dcb_dual_load_cache_tb.sv
`timescale 1ns/1ps
module dcb_dual_load_cache_tb;
   localparam int ADDR_W = 32;
   localparam int SETS   = 16;
   localparam int WAYS   = 2;
   localparam int LINE_W = ADDR_W - 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] req_valid = '0;
   logic [1:0] req_ready;
   logic [1:0][ADDR_W-1:0] req_addr = '0;
   logic [1:0] rsp_valid, rsp_hit, rsp_miss;
   logic [1:0][63:0] rsp_data;
   logic [1:0][LINE_W-1:0] rsp_line;
   logic fill_valid = 1'b0;
   logic [LINE_W-1:0] fill_line = '0;
   logic [511:0] fill_data = '0;

   always #2.5 clk = ~clk;

   dcb_dual_load_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_miss(rsp_miss), .rsp_data(rsp_data), .rsp_line(rsp_line),
      .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data));

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [LINE_W-1:0] m_line [SETS][WAYS];
   bit                m_vld  [SETS][WAYS];
   logic [511:0]      m_data [SETS][WAYS];
   int                m_rr   [SETS];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit m_find(input logic [LINE_W-1:0] line, output int way);
      int s = int'(line[3:0]);
      way = 0;
      for (int w = 0; w < WAYS; w++)
         if (m_vld[s][w] && m_line[s][w] == line) begin way = w; return 1; end
      return 0;
   endfunction

   function automatic logic [ADDR_W-1:0] mk_addr(input logic [LINE_W-1:0] line, input int word, input int off);
      return {line, 3'(word), 3'(off)};
   endfunction

   function automatic logic [511:0] rnd_line_data();
      logic [511:0] d;
      for (int i = 0; i < 16; i++) d[i*32 +: 32] = $urandom;
      return d;
   endfunction

   task automatic do_fill(input logic [LINE_W-1:0] line, input logic [511:0] data);
      int s = int'(line[3:0]);
      int v = -1;
      @(negedge clk);
      req_valid  = '0;
      fill_valid = 1'b1;
      fill_line  = line;
      fill_data  = data;
      #1;
      chk(req_ready == 2'b00, "R8 ready during fill", 64'(req_ready), 64'd0);
      @(negedge clk);
      fill_valid = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[s][w]) v = w;
      if (v < 0) begin
         v = m_rr[s];
         m_rr[s] = (m_rr[s] + 1) % WAYS;
      end
      m_vld[s][v]  = 1;
      m_line[s][v] = line;
      m_data[s][v] = data;
   endtask

   task automatic do_req(input bit v0, input logic [ADDR_W-1:0] a0,
                         input bit v1, input logic [ADDR_W-1:0] a1, output bit acc1);
      bit exp_r1;
      bit [1:0] acc;
      logic [ADDR_W-1:0] ad [2];
      int w;
      bit h;
      logic [63:0] ed;
      ad[0] = a0; ad[1] = a1;
      @(negedge clk);
      req_valid   = {v1, v0};
      req_addr[0] = a0;
      req_addr[1] = a1;
      #1;
      exp_r1 = !(v0 && (a0[5:3] == a1[5:3]));
      chk(req_ready[0] == 1'b1, "R3 port0 ready", 64'(req_ready[0]), 64'd1);
      chk(req_ready[1] == exp_r1, "R3 port1 ready", 64'(req_ready[1]), 64'(exp_r1));
      acc  = {v1 && exp_r1, v0};
      acc1 = acc[1];
      @(posedge clk);
      #1;
      req_valid = '0;
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         chk(rsp_valid[p] == acc[p], "R5 response valid", 64'(rsp_valid[p]), 64'(acc[p]));
         if (acc[p]) begin
            h  = m_find(ad[p][ADDR_W-1:6], w);
            ed = h ? m_data[int'(ad[p][9:6])][w][64*int'(ad[p][5:3]) +: 64] : 64'd0;
            chk(rsp_hit[p] == h && rsp_miss[p] == !h, "R6 hit/miss flags", 64'(rsp_hit[p]), 64'(h));
            chk(rsp_data[p] == ed, "R2 R6 R9 response data", rsp_data[p], ed);
            if (!h) chk(rsp_line[p] == ad[p][ADDR_W-1:6], "R6 miss line", 64'(rsp_line[p]), 64'(ad[p][ADDR_W-1:6]));
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [LINE_W-1:0] la, lb, lc, ld;
      logic [LINE_W-1:0] pool [12];
      bit a1;
      int dummy;
      void'($urandom(32'd20240611));
      for (int s = 0; s < SETS; s++) begin
         m_rr[s] = 0;
         for (int w = 0; w < WAYS; w++) m_vld[s][w] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(req_ready == 2'b11, "R1 ready after reset", 64'(req_ready), 64'd3);
      chk(rsp_valid == 2'b00, "R1 no response after reset", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      do_req(1, mk_addr(26'h12345, 2, 0), 1, mk_addr(26'h00abc, 5, 7), a1); // R1 all miss

      // R4 R2: one fill, both ports hit, different banks
      la = {22'h1, 4'd5}; lb = {22'h2, 4'd5}; lc = {22'h3, 4'd5}; ld = {22'h4, 4'd5};
      do_fill(la, rnd_line_data());
      do_req(1, mk_addr(la, 3, 0), 1, mk_addr(la, 6, 0), a1);
      chk(a1 == 1, "R3 different banks both accepted", 64'(a1), 64'd1);
      // R3 R9: same bank collision, different byte offsets
      do_req(1, mk_addr(la, 2, 1), 1, mk_addr(la, 2, 6), a1);
      chk(a1 == 0, "R3 same bank stalls port1", 64'(a1), 64'd0);
      do_req(0, '0, 1, mk_addr(la, 2, 6), a1);
      chk(a1 == 1, "R3 port1 served next cycle", 64'(a1), 64'd1);
      // R7: free way first, then rotation from way 0
      do_fill(lb, rnd_line_data());
      do_fill(lc, rnd_line_data());
      do_req(1, mk_addr(la, 0, 0), 1, mk_addr(lb, 1, 0), a1); // R7 la evicted
      chk(rsp_miss[0] == 1'b1, "R7 oldest rotation victim", 64'(rsp_miss[0]), 64'd1);
      do_fill(ld, rnd_line_data());
      do_req(1, mk_addr(lb, 4, 0), 1, mk_addr(lc, 7, 3), a1); // R7 lb evicted
      chk(rsp_miss[0] == 1'b1 && rsp_hit[1] == 1'b1, "R7 rotation wraps", 64'(rsp_hit), 64'd2);
      do_req(1, mk_addr(ld, 5, 2), 0, '0, a1);

      // random phase
      for (int i = 0; i < 12; i++) pool[i] = LINE_W'($urandom);
      for (int it = 0; it < 400; it++) begin
         logic [LINE_W-1:0] l0, l1;
         int w;
         if ($urandom_range(0, 5) == 0) begin
            l0 = pool[$urandom_range(0, 11)];
            if (!m_find(l0, w)) do_fill(l0, rnd_line_data());
         end
         l0 = ($urandom_range(0, 3) != 0) ? pool[$urandom_range(0, 11)] : LINE_W'($urandom);
         l1 = ($urandom_range(0, 3) != 0) ? pool[$urandom_range(0, 11)] : LINE_W'($urandom);
         dummy = $urandom_range(0, 7);
         do_req($urandom_range(0, 3) != 0, mk_addr(l0, dummy, $urandom_range(0, 7)),
                1, mk_addr(l1, $urandom_range(0, 7), $urandom_range(0, 7)), a1);
         if (!a1) do_req(0, '0, 1, req_addr[1], a1);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule